// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block models the front end of a synchronous burst static RAM, together with a small internal array of byte lanes. On every rising clock edge it samples the address, three chip enables, two address strobes, a burst step input and the write controls. From these it classifies the cycle as a deselect, a new read, a new write, a burst continue or a burst suspend.

One strobe is meant for a processor. It is masked by the primary enable and can only begin reads. The other strobe is meant for a cache or memory controller and can begin reads or writes. Bursts walk the two low address bits through four beats, in linear or interleaved order. A mode input selects either flow-through read data or read data taken through an extra output register. An asynchronous output enable gates the lane drivers. The data bus is presented as separate input data, output data and per-lane drive enables, which a pad ring combines into a bidirectional bus.

Top module: `burst_sram_ctl`

## Requirements
- R1: After reset no burst is active and every lane drive enable is low. A cycle with both strobes high and no active burst performs no access.
- R2: The block counts as selected only when `en_hi` is 1 and `en_lo_n` is 0. These two inputs are looked at only in cycles where a strobe is accepted, so they do not affect continue or suspend cycles.
- R3: When `en_pri_n` is 1, a low `stb_cpu_n` is ignored. If `stb_ctl_n` is also low, the cycle is a deselect: the burst ends and no access takes place. If `stb_ctl_n` is high, the cycle is treated as a continue or suspend cycle.
- R4: With `en_pri_n` low, a low `stb_cpu_n` and the block selected start a read at `addr`, whatever the write controls say.
- R5: With `stb_cpu_n` high and the block selected, a low `stb_ctl_n` starts an access at `addr` (and needs `en_pri_n` low). The access is a write if the write controls request one, and a read otherwise.
- R6: With both strobes high during an active burst, `step_n` low moves to the next burst address and `step_n` high repeats the current address. Read or write in these cycles follows the write controls, and a write uses `din` of that same cycle.
- R7: The burst changes only `addr[1:0]`, starting from the loaded value s. On beat n (0 to 3), `seq_linear_n` = 0 gives (s+n) mod 4 and `seq_linear_n` = 1 gives s XOR n. After the fourth beat the sequence returns to s.
- R8: `wr_all_n` = 0 writes all lanes. Otherwise, `wr_byte_n` = 0 writes each lane i whose `lane_sel_n[i]` is 0, where lane i is `din[9i+8:9i]`. `wr_byte_n` = 0 with no lane selected is a read.
- R9: A read raises all lane drive enables, whatever `lane_sel_n` says. The output slot of a write or deselect cycle leaves every lane undriven.
- R10: With `reg_out` = 0, data from a read sampled at edge k is driven after edge k. With `reg_out` = 1, it is driven after edge k+1.
- R11: `out_en_n` = 1 clears every drive enable at once, without waiting for a clock edge. `out_en_n` = 0 enables drivers only while read data is valid.
- R12: A read made while `out_en_n` is 1 still advances the burst address exactly like any other read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address |
| en_pri_n | input | 1 | Primary enable, active low; masks the processor strobe |
| en_hi | input | 1 | Secondary enable, active high |
| en_lo_n | input | 1 | Secondary enable, active low |
| stb_cpu_n | input | 1 | Processor address strobe, active low |
| stb_ctl_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| reg_out | input | 1 | 1 = registered output, 0 = flow-through |
| seq_linear_n | input | 1 | 0 = linear burst order, 1 = interleaved |
| din | input | LANES*LW | Write data |
| dout | output | LANES*LW | Read data |
| dout_oe | output | LANES | Per-lane drive enables |

## Verification
A wrong burst counter or a wrong order select shows up as wrong data on the very next read beat in flow-through mode. The bench therefore compares every beat of a burst against a reference array and its own model of the sequence. A misclassified cycle shows up one edge later: a write that was dropped or taken as a read, or drivers that switched on during a write or a deselect. Memory damage from such a cycle only appears on a later read-back, so each scenario reads back the words it could have corrupted. A wrong output register depth is visible as the drive enable arriving one cycle early or one cycle late.

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         addr,
  input  logic                  en_pri_n,
  input  logic                  en_hi,
  input  logic                  en_lo_n,
  input  logic                  stb_cpu_n,
  input  logic                  stb_ctl_n,
  input  logic                  step_n,
  input  logic                  wr_all_n,
  input  logic                  wr_byte_n,
  input  logic [LANES-1:0]      lane_sel_n,
  input  logic                  out_en_n,
  input  logic                  reg_out,
  input  logic                  seq_linear_n,
  input  logic [LANES*LW-1:0]   din,
  output logic [LANES*LW-1:0]   dout,
  output logic [LANES-1:0]      dout_oe
);
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic          active;
  logic [AW-1:0] base;
  logic [1:0]    cnt;

  logic sel, wr_req, p_go, c_go, start, desel, cont;
  logic [LANES-1:0] wmask;

  assign sel    = en_hi & ~en_lo_n;
  assign wr_req = ~wr_all_n | (~wr_byte_n & ~&lane_sel_n);
  assign wmask  = ~wr_all_n ? {LANES{1'b1}} : (~wr_byte_n ? ~lane_sel_n : '0);
  assign p_go   = ~stb_cpu_n & ~en_pri_n;
  assign c_go   = ~p_go & ~stb_ctl_n;
  assign start  = (p_go | (c_go & ~en_pri_n)) & sel;
  assign desel  = (p_go | c_go) & ~start;
  assign cont   = ~p_go & ~c_go & active;

  logic [1:0]    cnt_use, lsb_use;
  logic [AW-1:0] addr_use;
  logic          op_rd, op_wr;

  assign cnt_use  = step_n ? cnt : cnt + 2'd1;
  assign lsb_use  = seq_linear_n ? (base[1:0] ^ cnt_use) : (base[1:0] + cnt_use);
  assign addr_use = start ? addr : {base[AW-1:2], lsb_use};
  assign op_wr    = (start & c_go & wr_req) | (cont & wr_req);
  assign op_rd    = (start & ~(c_go & wr_req)) | (cont & ~wr_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      base   <= addr;
      cnt    <= '0;
    end else if (desel) begin
      active <= 1'b0;
    end else if (cont) begin
      cnt <= cnt_use;
    end
  end

  logic [DW-1:0] s1_d, s2_d;
  logic          s1_v, s2_v;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (op_wr && wmask[i]) mem[addr_use] <= din[i*LW +: LW];
      if (op_rd) s1_d[i*LW +: LW] <= mem[addr_use];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else begin
      s1_v <= op_rd;
      s2_v <= s1_v;
    end
  end

  always_ff @(posedge clk) s2_d <= s1_d;

  assign dout    = reg_out ? s2_d : s1_d;
  assign dout_oe = {LANES{(reg_out ? s2_v : s1_v) & ~out_en_n}};
endmodule

module burst_sram_ctl_chk #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_pri_n,
  input logic             en_hi,
  input logic             en_lo_n,
  input logic             stb_cpu_n,
  input logic             stb_ctl_n,
  input logic             wr_all_n,
  input logic             out_en_n,
  input logic             reg_out,
  input logic [LANES-1:0] dout_oe
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> dout_oe == '0);

  // R11
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> dout_oe == '0);

  // R9
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_ctl_n && stb_cpu_n && !en_pri_n && en_hi && !en_lo_n && !wr_all_n)
      |=> (reg_out || dout_oe == '0));

  // R3
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pri_n && !stb_ctl_n) |=> (reg_out || dout_oe == '0));

  // R10
  flow_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_cpu_n && !en_pri_n && en_hi && !en_lo_n && !reg_out)
      |=> (reg_out || out_en_n || dout_oe == '1));

  // R10
  pipe_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_cpu_n && !en_pri_n && en_hi && !en_lo_n && reg_out) ##1 reg_out
      |=> (!reg_out || out_en_n || dout_oe == '1));
endmodule

bind burst_sram_ctl burst_sram_ctl_chk #(.AW(AW), .LANES(LANES), .LW(LW)) u_chk (.*);

// File: tb/burst_sram_ctl_bench.sv
module burst_sram_ctl_bench;
  localparam int AW = 6, LANES = 4, LW = 9, DW = LANES * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic en_pri_n = 1'b0, en_hi = 1'b1, en_lo_n = 1'b0;
  logic stb_cpu_n = 1'b1, stb_ctl_n = 1'b1, step_n = 1'b1;
  logic wr_all_n = 1'b1, wr_byte_n = 1'b1;
  logic [LANES-1:0] lane_sel_n = '1;
  logic out_en_n = 1'b0, reg_out = 1'b0, seq_linear_n = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic [LANES-1:0] dout_oe;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [DW-1:0] ref_mem [1 << AW];

  always #10 clk = ~clk;

  burst_sram_ctl #(.AW(AW), .LANES(LANES), .LW(LW)) u_burst_sram_ctl (.*);

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    stb_cpu_n = 1; stb_ctl_n = 1; step_n = 1; en_pri_n = 0; en_hi = 1; en_lo_n = 0;
    wr_all_n = 1; wr_byte_n = 1; lane_sel_n = '1;
  endtask

  task automatic deselect();
    quiet(); stb_ctl_n = 0; en_pri_n = 1; tick(); quiet();
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] d,
                                          input logic [LANES-1:0] m);
    logic [DW-1:0] r = old;
    for (int i = 0; i < LANES; i++) if (m[i]) r[i*LW +: LW] = d[i*LW +: LW];
    return r;
  endfunction

  function automatic logic [AW-1:0] beat(input logic [AW-1:0] s, input int n, input logic inter);
    logic [1:0] l = inter ? (s[1:0] ^ 2'(n)) : (s[1:0] + 2'(n));
    return {s[AW-1:2], l};
  endfunction

  task automatic ctl_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    quiet(); stb_ctl_n = 0; addr = a; din = d; wr_all_n = 0; tick();
    ref_mem[a] = d; quiet();
  endtask

  task automatic flow_read(input string req, input logic [AW-1:0] a);
    quiet(); reg_out = 0; stb_ctl_n = 0; addr = a; tick(); quiet();
    chk({req, " drive"}, DW'(dout_oe), DW'({LANES{1'b1}}));
    chk({req, " data"}, dout, ref_mem[a]);
  endtask

  task automatic t_reset();
    chk("R1 oe after reset", DW'(dout_oe), '0);
    tick();
    chk("R1 idle cycle", DW'(dout_oe), '0);
  endtask

  task automatic t_linear_write_burst();
    seq_linear_n = 0; reg_out = 0;
    quiet(); stb_ctl_n = 0; addr = 6'h09; wr_all_n = 0; din = 36'h1_1111_1111; tick();
    ref_mem[6'h09] = din;
    chk("R9 no drive after write", DW'(dout_oe), '0);
    stb_ctl_n = 1;
    for (int n = 1; n < 4; n++) begin
      step_n = 0; din = 36'h2_0000_0000 + DW'(n * 36'h0_0101_0101); tick();
      ref_mem[beat(6'h09, n, 1'b0)] = din;
    end
    deselect();
    flow_read("R7 linear beat1", 6'h0A);
    flow_read("R7 linear beat2", 6'h0B);
    flow_read("R7 linear beat3 wrap", 6'h08);
    flow_read("R6 start", 6'h09);
    deselect();
  endtask

  task automatic t_interleaved_read_burst();
    seq_linear_n = 1; reg_out = 0;
    quiet(); stb_ctl_n = 0; addr = 6'h0A; tick(); quiet();
    chk("R7 inter beat0", dout, ref_mem[6'h0A]);
    for (int n = 1; n < 5; n++) begin
      step_n = 0; tick();
      chk("R7 inter beat", dout, ref_mem[beat(6'h0A, n % 4, 1'b1)]);
    end
    step_n = 1; tick();
    chk("R6 suspend repeats", dout, ref_mem[6'h0A]);
    stb_cpu_n = 0; en_pri_n = 1; step_n = 0; tick(); quiet();
    chk("R3 masked strobe continues", dout, ref_mem[6'h0B]);
    en_hi = 0; en_lo_n = 1; step_n = 0; tick(); quiet();
    chk("R2 enables ignored on continue", dout, ref_mem[6'h08]);
    out_en_n = 1; step_n = 0; tick();
    chk("R11 dummy read undriven", DW'(dout_oe), '0);
    out_en_n = 0; step_n = 0; tick();
    chk("R12 dummy read advanced", dout, ref_mem[6'h0A]);
    chk("R9 read drives all lanes", DW'(dout_oe), DW'({LANES{1'b1}}));
    out_en_n = 1; #1;
    chk("R11 async disable", DW'(dout_oe), '0);
    out_en_n = 0; #1;
    quiet(); stb_ctl_n = 0; en_pri_n = 1; tick(); quiet();
    chk("R3 deselect undriven", DW'(dout_oe), '0);
    tick();
    chk("R1 no access without burst", DW'(dout_oe), '0);
    seq_linear_n = 0;
  endtask

  task automatic t_pipeline();
    reg_out = 1;
    quiet(); stb_cpu_n = 0; addr = 6'h09; wr_all_n = 0; din = '1; tick();
    quiet(); stb_ctl_n = 0; en_pri_n = 1;
    chk("R10 pipe not yet", DW'(dout_oe), '0);
    tick(); quiet();
    chk("R10 pipe drive", DW'(dout_oe), DW'({LANES{1'b1}}));
    chk("R4 cpu strobe reads", dout, ref_mem[6'h09]);
    tick();
    chk("R10 pipe deselect slot", DW'(dout_oe), '0);
    reg_out = 0;
    flow_read("R4 memory unchanged", 6'h09);
    deselect();
  endtask

  task automatic t_select();
    reg_out = 0;
    quiet(); stb_cpu_n = 0; en_hi = 0; addr = 6'h0B; tick(); quiet();
    chk("R2 unselected read", DW'(dout_oe), '0);
    quiet(); stb_ctl_n = 0; en_lo_n = 1; addr = 6'h0B; wr_all_n = 0; din = 36'hF_0F0F_0F0F; tick(); quiet();
    flow_read("R2 unselected write dropped", 6'h0B);
    deselect();
  endtask

  task automatic t_bytes();
    ctl_write(6'h20, 36'hA_AAAA_AAAA);
    quiet(); stb_ctl_n = 0; addr = 6'h20; wr_byte_n = 0; lane_sel_n = 4'b1010;
    din = 36'h5_5555_5555; tick();
    ref_mem[6'h20] = merge(ref_mem[6'h20], din, 4'b0101);
    quiet();
    flow_read("R8 byte lanes", 6'h20);
    quiet(); stb_ctl_n = 0; addr = 6'h20; wr_byte_n = 0; lane_sel_n = 4'b1111; din = '0; tick(); quiet();
    chk("R8 no lane is read", DW'(dout_oe), DW'({LANES{1'b1}}));
    chk("R8 no lane data", dout, ref_mem[6'h20]);
    quiet(); stb_ctl_n = 0; addr = 6'h21; wr_all_n = 0; wr_byte_n = 0; lane_sel_n = 4'b1110;
    din = 36'h3_C3C3_C3C3; tick(); ref_mem[6'h21] = din; quiet();
    flow_read("R5 R8 global write", 6'h21);
    deselect();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_linear_write_burst();
    t_interleaved_read_burst();
    t_pipeline();
    t_select();
    t_bytes();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule